// File: doc/BRIEF.md
# NAND Page Read Sequencer

This block sits on the host side of an asynchronous 8-bit NAND bus and runs page reads without firmware help. A request supplies a 16-bit column address, a 24-bit row address, a page length and two mode inputs. The sequencer then issues the opening command byte and the five address bytes. It follows them with the confirm command, waits out the device's array access on the ready/busy line, and pulses read enable once per byte. Each byte goes out on a valid/ready stream.

If the request asks for more pages, the sequencer continues after each page. It issues a single cache-continue command cycle with no address, waits through the short busy interval that follows, and streams the next page. One mode input swaps the normal confirm byte for the cache-continue byte right after the address. A busy period that outlasts a programmable cycle limit aborts the request with an error pulse.

Top module: `nand_rd_seq`

## Requirements
- R1: While reset is held and afterwards in idle, `nand_cle`, `nand_ale`, `nand_dq_oe` and `out_valid` are 0, `nand_we_n` and `nand_re_n` are 1, and `req_ready` is 1.
- R2: An accepted request produces seven write cycles in this order: command 0x00, column bits 7:0, column bits 15:8, row bits 7:0, row bits 15:8, row bits 23:16, then the confirm command. `nand_cle` is high only on the two command cycles and `nand_ale` only on the five address cycles, and they are never high together.
- R3: The confirm command is 0x30 when `req_alt` is 0 and 0x31 when `req_alt` is 1.
- R4: Each write cycle holds `nand_we_n` low for WE_LO clocks and then high for WE_HI clocks, and `nand_dq_oe` is 1 only while `nand_we_n` is low.
- R5: For GUARD clocks after a confirm or cache-continue command, `nand_rb_n` is not sampled, so a device that is still showing ready in that window does not start the data phase.
- R6: After the guard window, no read-enable pulse starts until `nand_rb_n` has been seen high.
- R7: Each page yields exactly `req_len_m1`+1 read-enable low pulses. The sampled bytes appear on `out_data` in bus order, and `out_last` is 1 on the final byte of each page.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_data` holds steady and no new read-enable pulse begins.
- R9: When `req_more` is N>0, each of the N further pages is preceded by exactly one command cycle of 0x31 with no address cycles, then its own guard and busy wait.
- R10: If `nand_rb_n` stays low for `cfg_busy_limit` consecutive clocks after the guard, `err_timeout` pulses for one clock, the sequencer returns to idle (`req_ready`=1), and no data byte is delivered.
- R11: `done` pulses for one clock after the final byte of the final page is accepted, with the sequencer back in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Sequencer idle, request accepted on this clock |
| req_col | input | 16 | Column address |
| req_row | input | 24 | Row address |
| req_len_m1 | input | LEN_W | Bytes per page minus one |
| req_more | input | MORE_W | Number of cached pages after the first |
| req_alt | input | 1 | Confirm with 0x31 instead of 0x30 |
| cfg_busy_limit | input | TO_W | Busy timeout in clocks |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_dq_o | output | 8 | Bus byte driven to the device |
| nand_dq_oe | output | 1 | Bus drive enable |
| nand_dq_i | input | 8 | Bus byte from the device |
| nand_rb_n | input | 1 | Device ready (1) / busy (0) |
| out_valid | output | 1 | Stream byte valid |
| out_data | output | 8 | Stream byte |
| out_last | output | 1 | Final byte of a page |
| out_ready | input | 1 | Stream consumer ready |
| done | output | 1 | Request finished |
| err_timeout | output | 1 | Busy wait exceeded the limit |

## Verification
A corrupted write index shows within one write cycle as a misordered or mislabelled byte in the device's command log, or as a missing confirm. A wrong byte counter shows on the stream as a misplaced `out_last` or a miscounted read-enable pulse in the same page. A guard or busy-monitor fault shows at the first read-enable edge, which then precedes the ready edge. A lost timeout shows as a missing error pulse a few hundred clocks into a stuck busy.

// File: rtl/nrs_pkg.sv
package nrs_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_WLO, S_WHI, S_BUSY, S_RLO, S_PUSH, S_RHI
    } st_e;

    localparam logic [7:0] OP_OPEN   = 8'h00;
    localparam logic [7:0] OP_CONF   = 8'h30;
    localparam logic [7:0] OP_CACHE  = 8'h31;
    localparam int         COL_W     = 16;
    localparam int         ROW_W     = 24;
    localparam logic [2:0] IDX_CONF  = 3'd6;
    localparam logic [2:0] IDX_CONT  = 3'd7;

    function automatic int maxi(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/nrs_wsel.sv
module nrs_wsel
    import nrs_pkg::*;
(
    input  logic [2:0]       idx,
    input  logic [COL_W-1:0] col,
    input  logic [ROW_W-1:0] row,
    input  logic             alt,
    output logic [7:0]       wbyte,
    output logic             is_cmd,
    output logic             is_addr
);
    always_comb begin
        is_cmd  = 1'b0;
        is_addr = 1'b1;
        case (idx)
            3'd0: begin wbyte = OP_OPEN; is_cmd = 1'b1; is_addr = 1'b0; end
            3'd1: wbyte = col[7:0];
            3'd2: wbyte = col[15:8];
            3'd3: wbyte = row[7:0];
            3'd4: wbyte = row[15:8];
            3'd5: wbyte = row[23:16];
            3'd6: begin wbyte = alt ? OP_CACHE : OP_CONF; is_cmd = 1'b1; is_addr = 1'b0; end
            default: begin wbyte = OP_CACHE; is_cmd = 1'b1; is_addr = 1'b0; end
        endcase
    end
endmodule

// File: rtl/nrs_busy_mon.sv
module nrs_busy_mon #(
    parameter int GUARD = 25,
    parameter int TO_W  = 20,
    parameter int SYNC  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            rb_n,
    input  logic [TO_W-1:0] limit,
    output logic            go,
    output logic            tmo
);
    localparam int GW = $clog2(GUARD + 1);

    typedef enum logic [1:0] {P_IDLE, P_GUARD, P_WAIT} ph_e;

    typedef struct packed {
        ph_e             ph;
        logic [GW-1:0]   gcnt;
        logic [TO_W-1:0] lcnt;
        logic            go;
        logic            tmo;
    } mon_t;

    mon_t r, n;
    logic rb_s;

    generate
        if (SYNC <= 1) begin : g_sync1
            logic s_q;
            always_ff @(posedge clk) begin
                if (!rst_n) s_q <= 1'b1;
                else        s_q <= rb_n;
            end
            assign rb_s = s_q;
        end else begin : g_syncn
            logic [SYNC-1:0] s_q;
            always_ff @(posedge clk) begin
                if (!rst_n) s_q <= '1;
                else        s_q <= {s_q[SYNC-2:0], rb_n};
            end
            assign rb_s = s_q[SYNC-1];
        end
    endgenerate

    always_comb begin
        n     = r;
        n.go  = 1'b0;
        n.tmo = 1'b0;
        case (r.ph)
            P_IDLE: begin
                if (start) begin
                    n.ph   = P_GUARD;
                    n.gcnt = GW'(GUARD);
                end
            end
            P_GUARD: begin
                if (r.gcnt == '0) begin
                    n.ph   = P_WAIT;
                    n.lcnt = '0;
                end else begin
                    n.gcnt = r.gcnt - 1'b1;
                end
            end
            P_WAIT: begin
                if (rb_s) begin
                    n.go = 1'b1;
                    n.ph = P_IDLE;
                end else if (r.lcnt == limit - 1'b1) begin
                    n.tmo = 1'b1;
                    n.ph  = P_IDLE;
                end else begin
                    n.lcnt = r.lcnt + 1'b1;
                end
            end
            default: n.ph = P_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r <= '{ph: P_IDLE, gcnt: '0, lcnt: '0, go: 1'b0, tmo: 1'b0};
        end else begin
            r <= n;
        end
    end

    assign go  = r.go;
    assign tmo = r.tmo;

    // R5: a start is never answered on the next clock
    a_r5_no_early_go: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !go);
    // R10: ready and timeout are exclusive outcomes
    a_r10_go_tmo_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(go && tmo));
    // R10: timeout is a single-clock pulse
    a_r10_tmo_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tmo |=> !tmo);
endmodule

// File: rtl/nand_rd_seq.sv
module nand_rd_seq
    import nrs_pkg::*;
#(
    parameter int LEN_W  = 12,
    parameter int MORE_W = 4,
    parameter int TO_W   = 20,
    parameter int WE_LO  = 3,
    parameter int WE_HI  = 3,
    parameter int RE_LO  = 3,
    parameter int RE_HI  = 3,
    parameter int GUARD  = 25,
    parameter int SYNC   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [15:0]       req_col,
    input  logic [23:0]       req_row,
    input  logic [LEN_W-1:0]  req_len_m1,
    input  logic [MORE_W-1:0] req_more,
    input  logic              req_alt,
    input  logic [TO_W-1:0]   cfg_busy_limit,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [7:0]        nand_dq_o,
    output logic              nand_dq_oe,
    input  logic [7:0]        nand_dq_i,
    input  logic              nand_rb_n,
    output logic              out_valid,
    output logic [7:0]        out_data,
    output logic              out_last,
    input  logic              out_ready,
    output logic              done,
    output logic              err_timeout
);
    localparam int TMAX = maxi(maxi(WE_LO, WE_HI), maxi(RE_LO, RE_HI));
    localparam int TW   = $clog2(TMAX + 1);

    typedef struct packed {
        st_e               st;
        logic [TW-1:0]     tcnt;
        logic [2:0]        widx;
        logic [COL_W-1:0]  col;
        logic [ROW_W-1:0]  row;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  bcnt;
        logic [MORE_W-1:0] more;
        logic              alt;
        logic [7:0]        dq;
        logic [7:0]        data;
        logic              cle;
        logic              ale;
        logic              we_n;
        logic              re_n;
        logic              oe;
        logic              ovalid;
        logic              olast;
        logic              done;
        logic              err;
        logic              start;
    } seq_t;

    seq_t       r, n;
    logic [2:0] sel_idx;
    logic [7:0] ws_byte;
    logic       ws_cmd, ws_addr;
    logic       bm_go, bm_tmo;
    logic       go_w;

    // index of the write cycle that would start next
    always_comb begin
        if (r.st == S_WHI)       sel_idx = r.widx + 3'd1;
        else if (r.st == S_IDLE) sel_idx = 3'd0;
        else                     sel_idx = IDX_CONT;
    end

    nrs_wsel u_wsel (
        .idx     (sel_idx),
        .col     (r.col),
        .row     (r.row),
        .alt     (r.alt),
        .wbyte   (ws_byte),
        .is_cmd  (ws_cmd),
        .is_addr (ws_addr)
    );

    nrs_busy_mon #(.GUARD(GUARD), .TO_W(TO_W), .SYNC(SYNC)) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .start (r.start),
        .rb_n  (nand_rb_n),
        .limit (cfg_busy_limit),
        .go    (bm_go),
        .tmo   (bm_tmo)
    );

    always_comb begin
        n       = r;
        n.done  = 1'b0;
        n.err   = 1'b0;
        n.start = 1'b0;
        go_w    = 1'b0;
        case (r.st)
            S_IDLE: begin
                if (req_valid) begin
                    n.col  = req_col;
                    n.row  = req_row;
                    n.len  = req_len_m1;
                    n.more = req_more;
                    n.alt  = req_alt;
                    go_w   = 1'b1;
                end
            end
            S_WLO: begin
                if (r.tcnt == '0) begin
                    n.we_n = 1'b1;
                    n.oe   = 1'b0;
                    n.tcnt = TW'(WE_HI - 1);
                    n.st   = S_WHI;
                end else begin
                    n.tcnt = r.tcnt - 1'b1;
                end
            end
            S_WHI: begin
                if (r.tcnt == '0) begin
                    n.cle = 1'b0;
                    n.ale = 1'b0;
                    if (r.widx >= IDX_CONF) begin
                        n.st    = S_BUSY;
                        n.start = 1'b1;
                    end else begin
                        go_w = 1'b1;
                    end
                end else begin
                    n.tcnt = r.tcnt - 1'b1;
                end
            end
            S_BUSY: begin
                if (bm_tmo) begin
                    n.err = 1'b1;
                    n.st  = S_IDLE;
                end else if (bm_go) begin
                    n.st   = S_RLO;
                    n.re_n = 1'b0;
                    n.tcnt = TW'(RE_LO - 1);
                    n.bcnt = '0;
                end
            end
            S_RLO: begin
                if (r.tcnt == '0) begin
                    n.data   = nand_dq_i;
                    n.re_n   = 1'b1;
                    n.ovalid = 1'b1;
                    n.olast  = (r.bcnt == r.len);
                    n.st     = S_PUSH;
                end else begin
                    n.tcnt = r.tcnt - 1'b1;
                end
            end
            S_PUSH: begin
                if (out_ready) begin
                    n.ovalid = 1'b0;
                    if (!r.olast) begin
                        n.st   = S_RHI;
                        n.tcnt = TW'(RE_HI - 1);
                        n.bcnt = r.bcnt + 1'b1;
                    end else if (r.more != '0) begin
                        n.more = r.more - 1'b1;
                        go_w   = 1'b1;
                    end else begin
                        n.done = 1'b1;
                        n.st   = S_IDLE;
                    end
                end
            end
            S_RHI: begin
                if (r.tcnt == '0) begin
                    n.st   = S_RLO;
                    n.re_n = 1'b0;
                    n.tcnt = TW'(RE_LO - 1);
                end else begin
                    n.tcnt = r.tcnt - 1'b1;
                end
            end
            default: n.st = S_IDLE;
        endcase
        if (go_w) begin
            n.st   = S_WLO;
            n.widx = sel_idx;
            n.cle  = ws_cmd;
            n.ale  = ws_addr;
            n.dq   = ws_byte;
            n.oe   = 1'b1;
            n.we_n = 1'b0;
            n.tcnt = TW'(WE_LO - 1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r      <= '0;
            r.st   <= S_IDLE;
            r.we_n <= 1'b1;
            r.re_n <= 1'b1;
        end else begin
            r <= n;
        end
    end

    assign req_ready   = (r.st == S_IDLE);
    assign nand_cle    = r.cle;
    assign nand_ale    = r.ale;
    assign nand_we_n   = r.we_n;
    assign nand_re_n   = r.re_n;
    assign nand_dq_o   = r.dq;
    assign nand_dq_oe  = r.oe;
    assign out_valid   = r.ovalid;
    assign out_data    = r.data;
    assign out_last    = r.olast;
    assign done        = r.done;
    assign err_timeout = r.err;

    // R2: command and address latches never overlap
    a_r2_cle_ale_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));
    // R4: bus driven only while write enable is low
    a_r4_oe_we_low: assert property (@(posedge clk) disable iff (!rst_n)
        nand_dq_oe |-> !nand_we_n);
    // R4: a write pulse never overlaps a read pulse
    a_r4_we_re_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));
    // R8: a pending byte holds until accepted
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    // R8: no read pulse while a byte is pending
    a_r8_no_re_pending: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> nand_re_n);
    // R10: an error leaves the sequencer idle
    a_r10_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |-> (req_ready && !out_valid));
    // R11: completion is a single pulse in idle
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (req_ready && !err_timeout));
endmodule

// File: tb/nand_rd_seq_tb.sv
module nand_rd_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_col = '0;
    logic [23:0] req_row = '0;
    logic [11:0] req_len_m1 = '0;
    logic [3:0]  req_more = '0;
    logic        req_alt = 1'b0;
    logic [19:0] cfg_busy_limit = 20'd1000;
    logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]  nand_dq_o;
    logic [7:0]  nand_dq_i = '0;
    logic        nand_rb_n = 1'b1;
    logic        out_valid, out_last;
    logic [7:0]  out_data;
    logic        out_ready = 1'b1;
    logic        done, err_timeout;

    always #2 clk = ~clk;

    nand_rd_seq u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_col(req_col), .req_row(req_row), .req_len_m1(req_len_m1),
        .req_more(req_more), .req_alt(req_alt), .cfg_busy_limit(cfg_busy_limit),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe),
        .nand_dq_i(nand_dq_i), .nand_rb_n(nand_rb_n),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .out_ready(out_ready), .done(done), .err_timeout(err_timeout)
    );

    int n_vec = 0, n_mis = 0;
    int cyc = 0;
    // device model state
    logic [7:0] log_b [0:31];
    logic [1:0] log_t [0:31];
    int log_n = 0, conf_n = 0, ridx = 0, bdly = 0, bleft = 0;
    int busy_first = 60, busy_next = 10;
    int re_falls = 0, re_viol = 0, rb_rise_cyc = 0, first_re_cyc = 0;
    logic pwe = 1'b1, pre = 1'b1;
    // stream capture
    logic [7:0] rx_b [0:63];
    logic       rx_l [0:63];
    int rx_n = 0, rdy_mode = 0;
    bit done_seen = 0, err_seen = 0;

    function automatic logic [7:0] pat(input int p, input int k);
        return {p[3:0], 4'h0} ^ k[7:0] ^ 8'h5A;
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // NAND device model
    always @(negedge clk) begin
        if (!pwe && nand_we_n) begin
            log_b[log_n[4:0]] = nand_dq_o;
            log_t[log_n[4:0]] = {nand_cle, nand_ale};
            log_n++;
            if (nand_cle && (nand_dq_o == 8'h30 || nand_dq_o == 8'h31)) begin
                bdly  = 20;
                bleft = (conf_n == 0) ? busy_first : busy_next;
                conf_n++;
                ridx = 0;
            end
        end
        if (bdly > 0) begin
            bdly--;
            if (bdly == 0) nand_rb_n = 1'b0;
        end else if (!nand_rb_n) begin
            if (bleft == 0) begin
                nand_rb_n   = 1'b1;
                rb_rise_cyc = cyc;
            end else bleft--;
        end
        if (pre && !nand_re_n) begin
            nand_dq_i = pat(conf_n - 1, ridx);
            ridx++;
            re_falls++;
            if (first_re_cyc == 0) first_re_cyc = cyc;
            if (out_valid) re_viol++;
        end
        pwe = nand_we_n;
        pre = nand_re_n;
    end

    // stream consumer
    always @(negedge clk) begin
        logic r;
        r = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) == 0);
        out_ready = r;
        if (out_valid && r && rx_n < 64) begin
            rx_b[rx_n] = out_data;
            rx_l[rx_n] = out_last;
            rx_n++;
        end
        if (done) done_seen = 1;
        if (err_timeout) err_seen = 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_mis++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_logs();
        @(posedge clk);
        log_n = 0; conf_n = 0; ridx = 0; re_falls = 0; re_viol = 0;
        rb_rise_cyc = 0; first_re_cyc = 0; rx_n = 0;
        done_seen = 0; err_seen = 0;
    endtask

    task automatic run_req(input logic [15:0] col, input logic [23:0] row,
                           input int len_m1, input int more, input logic alt);
        clear_logs();
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_col = col; req_row = row; req_len_m1 = 12'(len_m1);
        req_more = 4'(more); req_alt = alt; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done_seen && !err_seen) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic chk_header(input logic [15:0] col, input logic [23:0] row,
                              input logic [7:0] conf);
        logic [7:0] eb [0:6];
        eb[0] = 8'h00; eb[1] = col[7:0]; eb[2] = col[15:8];
        eb[3] = row[7:0]; eb[4] = row[15:8]; eb[5] = row[23:16]; eb[6] = conf;
        for (int i = 0; i < 7; i++) begin
            chk($sformatf("R2 write byte %0d", i), int'(log_b[i]), int'(eb[i]));
            chk($sformatf("R2 cle/ale kind %0d", i), int'(log_t[i]),
                (i == 0 || i == 6) ? 2 : 1);
        end
    endtask

    task automatic chk_pages(input int pages, input int len);
        chk("R7 byte count", rx_n, pages * len);
        chk("R7 read pulses", re_falls, pages * len);
        for (int p = 0; p < pages; p++)
            for (int k = 0; k < len; k++) begin
                chk($sformatf("R7 data p%0d b%0d", p, k),
                    int'(rx_b[p*len+k]), int'(pat(p, k)));
                chk($sformatf("R7 last p%0d b%0d", p, k),
                    int'(rx_l[p*len+k]), (k == len-1) ? 1 : 0);
            end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 cle", nand_cle, 0);
        chk("R1 ale", nand_ale, 0);
        chk("R1 we_n", nand_we_n, 1);
        chk("R1 re_n", nand_re_n, 1);
        chk("R1 dq_oe", nand_dq_oe, 0);
        chk("R1 out_valid", out_valid, 0);
        chk("R1 req_ready", req_ready, 1);
    endtask

    task automatic t_plain();
        run_req(16'h1234, 24'h56789A, 3, 0, 1'b0);
        chk("R2 write count", log_n, 7);
        chk_header(16'h1234, 24'h56789A, 8'h30);   // R3 confirm 0x30
        chk_pages(1, 4);
        chk("R5 R6 read after ready edge", int'(first_re_cyc > rb_rise_cyc), 1);
        chk("R11 done", done_seen, 1);
        chk("R11 idle after done", req_ready, 1);
    endtask

    task automatic t_alt();
        run_req(16'hBEEF, 24'h0C0FFE, 1, 0, 1'b1);
        chk_header(16'hBEEF, 24'h0C0FFE, 8'h31);   // R3 confirm 0x31
        chk_pages(1, 2);
    endtask

    task automatic t_cache();
        run_req(16'h0001, 24'h000203, 2, 2, 1'b0);
        chk("R9 write count", log_n, 9);
        chk_header(16'h0001, 24'h000203, 8'h30);
        for (int i = 7; i < 9; i++) begin
            chk($sformatf("R9 continue byte %0d", i), int'(log_b[i]), 8'h31);
            chk($sformatf("R9 continue kind %0d", i), int'(log_t[i]), 2);
        end
        chk_pages(3, 3);
        chk("R11 done after cache", done_seen, 1);
    endtask

    task automatic t_backpressure();
        rdy_mode = 1;
        run_req(16'h0F0F, 24'hA0B0C0, 7, 0, 1'b0);
        rdy_mode = 0;
        chk_pages(1, 8);
        chk("R8 read pulse while pending", re_viol, 0);
    endtask

    task automatic t_timeout();
        busy_first = 3000;
        cfg_busy_limit = 20'd200;
        run_req(16'h0000, 24'h000001, 3, 0, 1'b0);
        chk("R10 err pulse", err_seen, 1);
        chk("R10 no done", done_seen, 0);
        chk("R10 no data", rx_n, 0);
        chk("R10 no read pulse", re_falls, 0);
        chk("R10 idle", req_ready, 1);
        while (!nand_rb_n || bdly != 0) @(negedge clk);
        busy_first = 60;
        cfg_busy_limit = 20'd1000;
    endtask

    initial begin
        repeat (5) @(posedge clk);
        t_reset();
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_plain();
        t_alt();
        t_cache();
        t_backpressure();
        t_timeout();
        t_plain();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_mis);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++;
        n_mis++;
        $display("FAIL R11 watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_mis);
        $finish;
    end
endmodule